// File: doc/BRIEF.md
# Chained Page-Table Address Translator

This block maps a linear trace-buffer address onto a physical address using page tables that sit in memory and are chained to each other. Each table is one 4 KB page of 64-bit entries. Slots 0 to 255 point at 4 KB data pages, so one table covers a 1 MB window of input space. Slot 510 holds a link back to the previous table and slot 511 holds a link forward to the next one. Bit 0 of every entry or link is its valid flag. Bits 11:1 must be zero. The page address occupies bit 12 upward.

Software configures three values: the 1 MB window of input space that maps onto the first table, the page number of the first table, and how many tables the chain holds. A request arrives with a valid/ready handshake. The block keeps one table cached: its page number and its window number. If the request falls in the cached window, the block makes one entry fetch. Otherwise it steps along the chain one link per memory read, forward or backward, until it reaches the window it needs. It then fetches the entry and returns the physical page joined to the untouched 12-bit page offset, or it returns a fault.

The memory read port allows one outstanding read. The block holds the request and the address until the read-valid strobe arrives.

Top module: `chain_xlate`

## Requirements
- R1: After reset the block is idle: req_ready_o is 1 and mem_req_o and rsp_valid_o are 0. After a configuration write, a request in window 0 needs exactly one memory read.
- R2: For a request in the cached window, the block reads address (table page << 12) + va[19:12]*8. It returns rsp_pa_o = {entry[PAW-1:12], va[11:0]} with rsp_fault_o = 0. mem_addr_o stays stable while mem_req_o waits for mem_rvalid_i.
- R3: An entry fails, giving rsp_fault_o = 1 and rsp_pa_o = 0, when any of these holds: bit 0 is 0, any of bits 11:1 is set, or any bit at or above PAW is set.
- R4: When the target window is above the cached one, the block reads slot 511 of the cached table, at offset 0xFF8. It moves up one table per valid link. One request costs (target − cached) link reads plus one entry read.
- R5: When the target window is below the cached one, the block reads slot 0x1FE (510), at offset 0xFF0, one step per read. It makes (cached − target) link reads plus one entry read.
- R6: A link that fails the R3 validity test ends the walk with a fault and no further reads. The cached table stays at the last table it reached.
- R7: A request whose address window lies below the configured input window faults without any memory read.
- R8: The relative window w is the input window minus the base window. If count ≤ w < 2·count, it wraps to w − count. If w ≥ 2·count, the request faults with no memory read.
- R9: A configuration write returns the cache to the first table and puts the block in the idle state.
- R10: The cached table persists between requests. A second request in the same window as the previous one makes exactly one read.
- R11: A request is taken when req_valid_i and req_ready_o are both 1. req_ready_o is 0 from the cycle after acceptance until the response. Every accepted request gets exactly one rsp_valid_o pulse, one cycle long, and the block is ready in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_in_win_i | input | WW | 1 MB window number of the input base |
| cfg_tbl_page_i | input | PAW-12 | 4 KB page number of the first table |
| cfg_tables_i | input | TW | Number of tables in the chain |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Ready to take a request |
| req_va_i | input | VAW | Linear address to translate |
| mem_req_o | output | 1 | Table read request, held until the read returns |
| mem_addr_o | output | PAW | Byte address of the 64-bit table word |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Table word read back |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_pa_o | output | PAW | Translated physical address, 0 on fault |
| rsp_fault_o | output | 1 | Translation failed |

## Verification
A wrong cached window or table page does not fault at once. It shows up on the next request: that request makes a different number of memory reads, or reads from the wrong table, so it returns a physical page that belongs to another table. The bench counts the reads for each request and checks the returned address against a model of the chain. It also mirrors the cached window, so the first request after a wrong step fails. An invalid link is placed in the middle of the chain, and a follow-up request checks where the cache stopped.

// File: rtl/chain_xlate_pkg.sv
package chain_xlate_pkg;
  localparam int unsigned ENT_W    = 64;
  localparam int unsigned PG_SH    = 12;
  localparam int unsigned WIN_SH   = 20;
  localparam int unsigned SLOT_W   = 9;
  localparam logic [SLOT_W-1:0] SLOT_PREV = 9'd510;
  localparam logic [SLOT_W-1:0] SLOT_NEXT = 9'd511;

  typedef enum logic [1:0] {S_IDLE, S_DEC, S_FETCH, S_RESP} state_e;
  typedef enum logic [1:0] {K_ENTRY, K_NEXT, K_PREV} kind_e;
endpackage

// File: rtl/chain_xlate_win.sv
module chain_xlate_win #(
  parameter int unsigned WW = 12,
  parameter int unsigned TW = 8
) (
  input  logic [WW-1:0] va_win_i,
  input  logic [WW-1:0] base_win_i,
  input  logic [TW-1:0] tables_i,
  input  logic [TW-1:0] cur_win_i,
  output logic [TW-1:0] tgt_o,
  output logic          fault_o,
  output logic          same_o,
  output logic          up_o
);
  localparam int unsigned XW = WW + 2;

  logic [XW-1:0] rel, cnt;

  always_comb begin
    rel     = XW'(va_win_i - base_win_i);
    cnt     = XW'(tables_i);
    tgt_o   = '0;
    fault_o = 1'b0;
    if (va_win_i < base_win_i) begin
      fault_o = 1'b1;
    end else if (rel < cnt) begin
      tgt_o = TW'(rel);
    end else if (rel < (cnt << 1)) begin
      tgt_o = TW'(rel - cnt);
    end else begin
      fault_o = 1'b1;
    end
    same_o = (tgt_o == cur_win_i);
    up_o   = (tgt_o > cur_win_i);
  end
endmodule

// File: rtl/chain_xlate_cache.sv
module chain_xlate_cache #(
  parameter int unsigned PPW = 28,
  parameter int unsigned TW  = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [PPW-1:0] first_page_i,
  input  logic           step_i,
  input  logic           up_i,
  input  logic [PPW-1:0] link_page_i,
  output logic [PPW-1:0] page_o,
  output logic [TW-1:0]  win_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_o <= '0;
      win_o  <= '0;
    end else if (load_i) begin
      page_o <= first_page_i;
      win_o  <= '0;
    end else if (step_i) begin
      page_o <= link_page_i;
      win_o  <= up_i ? win_o + 1'b1 : win_o - 1'b1;
    end
  end
endmodule

// File: rtl/chain_xlate.sv
module chain_xlate
  import chain_xlate_pkg::*;
#(
  parameter int unsigned VAW = 32,
  parameter int unsigned PAW = 40,
  parameter int unsigned TW  = 8,
  parameter int unsigned WW  = VAW - WIN_SH,
  parameter int unsigned PPW = PAW - PG_SH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [WW-1:0]     cfg_in_win_i,
  input  logic [PPW-1:0]    cfg_tbl_page_i,
  input  logic [TW-1:0]     cfg_tables_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VAW-1:0]    req_va_i,
  output logic              mem_req_o,
  output logic [PAW-1:0]    mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [ENT_W-1:0]  mem_rdata_i,
  output logic              rsp_valid_o,
  output logic [PAW-1:0]    rsp_pa_o,
  output logic              rsp_fault_o
);
  state_e          state_q;
  kind_e           kind_q;
  logic [VAW-1:0]  va_q;
  logic [WW-1:0]   base_win_q;
  logic [TW-1:0]   tables_q;
  logic [PPW-1:0]  cur_page;
  logic [TW-1:0]   cur_win;
  logic [TW-1:0]   tgt_win;
  logic            win_fault, win_same, win_up;
  logic            word_ok, step;
  logic [PPW-1:0]  rd_page;

  // page bits plus zero reserved bits plus valid flag
  assign word_ok = mem_rdata_i[0] && (mem_rdata_i[PG_SH-1:1] == '0)
                   && (mem_rdata_i[ENT_W-1:PAW] == '0);
  assign rd_page = mem_rdata_i[PAW-1:PG_SH];
  assign step    = (state_q == S_FETCH) && mem_rvalid_i && (kind_q != K_ENTRY)
                   && word_ok && !cfg_we_i;

  chain_xlate_win #(.WW(WW), .TW(TW)) u_win (
    .va_win_i  (va_q[VAW-1:WIN_SH]),
    .base_win_i(base_win_q),
    .tables_i  (tables_q),
    .cur_win_i (cur_win),
    .tgt_o     (tgt_win),
    .fault_o   (win_fault),
    .same_o    (win_same),
    .up_o      (win_up)
  );

  chain_xlate_cache #(.PPW(PPW), .TW(TW)) u_cache (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (cfg_we_i),
    .first_page_i(cfg_tbl_page_i),
    .step_i      (step),
    .up_i        (kind_q == K_NEXT),
    .link_page_i (rd_page),
    .page_o      (cur_page),
    .win_o       (cur_win)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      kind_q      <= K_ENTRY;
      va_q        <= '0;
      base_win_q  <= '0;
      tables_q    <= '0;
      mem_addr_o  <= '0;
      rsp_pa_o    <= '0;
      rsp_fault_o <= 1'b0;
    end else if (cfg_we_i) begin
      base_win_q <= cfg_in_win_i;
      tables_q   <= cfg_tables_i;
      state_q    <= S_IDLE;
    end else begin
      case (state_q)
        S_IDLE: if (req_valid_i) begin
          va_q    <= req_va_i;
          state_q <= S_DEC;
        end
        S_DEC: begin
          if (win_fault) begin
            rsp_pa_o    <= '0;
            rsp_fault_o <= 1'b1;
            state_q     <= S_RESP;
          end else begin
            state_q <= S_FETCH;
            if (win_same) begin
              kind_q     <= K_ENTRY;
              mem_addr_o <= {cur_page, 1'b0, va_q[WIN_SH-1:PG_SH], 3'b000};
            end else if (win_up) begin
              kind_q     <= K_NEXT;
              mem_addr_o <= {cur_page, SLOT_NEXT, 3'b000};
            end else begin
              kind_q     <= K_PREV;
              mem_addr_o <= {cur_page, SLOT_PREV, 3'b000};
            end
          end
        end
        S_FETCH: if (mem_rvalid_i) begin
          if (kind_q == K_ENTRY) begin
            rsp_pa_o    <= word_ok ? {rd_page, va_q[PG_SH-1:0]} : '0;
            rsp_fault_o <= !word_ok;
            state_q     <= S_RESP;
          end else if (word_ok) begin
            state_q <= S_DEC;
          end else begin
            rsp_pa_o    <= '0;
            rsp_fault_o <= 1'b1;
            state_q     <= S_RESP;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == S_IDLE);
  assign mem_req_o   = (state_q == S_FETCH);
  assign rsp_valid_o = (state_q == S_RESP);
endmodule

// File: rtl/chain_xlate_chk.sv
module chain_xlate_chk #(
  parameter int unsigned PAW = 40
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cfg_we_i,
  input logic           req_valid_i,
  input logic           req_ready_o,
  input logic           mem_req_o,
  input logic [PAW-1:0] mem_addr_o,
  input logic           mem_rvalid_i,
  input logic           rsp_valid_o
);
  p_addr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i && !cfg_we_i |=> mem_req_o && $stable(mem_addr_o));

  p_word_align_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[2:0] == 3'b000);

  // only data slots or the two link slots are ever read (R4, R5)
  p_link_slot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && (mem_addr_o[11:3] > 9'd255) |-> mem_addr_o[11:3] >= 9'd510);

  p_busy_after_take_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && !cfg_we_i |=> !req_ready_o);

  p_resp_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && req_ready_o);

  p_resp_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !mem_req_o && !req_ready_o);

  p_cfg_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> req_ready_o && !mem_req_o && !rsp_valid_o);
endmodule

bind chain_xlate chain_xlate_chk #(.PAW(PAW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_rvalid_i(mem_rvalid_i),
  .rsp_valid_o (rsp_valid_o)
);

// File: tb/chain_xlate_test.sv
module chain_xlate_test;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 6;
  localparam logic [11:0] BASE_WIN = 12'h030;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [11:0] cfg_win = '0;
  logic [27:0] cfg_page = '0;
  logic [7:0]  cfg_tables = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic        mem_req;
  logic [39:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        rsp_valid;
  logic [39:0] rsp_pa;
  logic        rsp_fault;

  int n_tests = 0, n_fail = 0, fetch_cnt = 0, exp_cur = 0, bad_next = -1;

  always #(CLK_PERIOD/2) clk = ~clk;

  chain_xlate uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_in_win_i(cfg_win),
    .cfg_tbl_page_i(cfg_page), .cfg_tables_i(cfg_tables),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_va_i(req_va),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .rsp_valid_o(rsp_valid), .rsp_pa_o(rsp_pa),
    .rsp_fault_o(rsp_fault)
  );

  function automatic logic [39:0] tbl_addr(input int k);
    return 40'h40000 + 40'((k * 5) % 8) * 40'h1000;
  endfunction

  function automatic logic [27:0] data_page(input int k, input int i);
    return 28'((k * 256 + i) * 7 + 291);
  endfunction

  function automatic logic [63:0] entry_word(input int k, input int i);
    logic [63:0] w;
    w = {24'h0, data_page(k, i), 12'h001};
    if ((k == 2 && i == 37) || (k == 4 && i == 0)) w[0] = 1'b0;
    if (k == 1 && i == 200) w[5] = 1'b1;
    return w;
  endfunction

  function automatic logic [63:0] mem_read(input logic [39:0] a);
    for (int k = 0; k < NT; k++) begin
      if (a[39:12] == tbl_addr(k) >> 12) begin
        int idx;
        idx = int'(a[11:3]);
        if (idx < 256) return entry_word(k, idx);
        if (idx == 510) return (k > 0) ? {24'h0, tbl_addr(k - 1)} | 64'h1 : 64'h0;
        if (idx == 511) return (k < NT - 1 && k != bad_next) ?
                               {24'h0, tbl_addr(k + 1)} | 64'h1 : 64'h0;
        return 64'h0;
      end
    end
    return 64'h0;
  endfunction

  function automatic void model(input logic [31:0] va, output bit f,
                                output logic [39:0] pa, output int nf);
    int w, t, idx;
    logic [63:0] e;
    f = 1'b0; pa = '0; nf = 0;
    if (va[31:20] < BASE_WIN) begin f = 1'b1; return; end
    w = int'(va[31:20] - BASE_WIN);
    if (w >= 2 * NT) begin f = 1'b1; return; end
    t = (w >= NT) ? w - NT : w;
    while (exp_cur < t) begin
      nf++;
      if (exp_cur == bad_next) begin f = 1'b1; return; end
      exp_cur++;
    end
    while (exp_cur > t) begin nf++; exp_cur--; end
    nf++;
    idx = int'(va[19:12]);
    e = entry_word(t, idx);
    if (e[0] && e[11:1] == '0) pa = {e[39:12], va[11:0]};
    else f = 1'b1;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (mem_req) begin
        int lat;
        lat = int'($urandom % 3);
        repeat (lat) @(negedge clk);
        mem_rdata  = mem_read(mem_addr);
        mem_rvalid = 1'b1;
        fetch_cnt++;
      end
    end
  end

  task automatic configure();
    @(negedge clk);
    cfg_we = 1'b1; cfg_win = BASE_WIN; cfg_page = tbl_addr(0) >> 12; cfg_tables = 8'(NT);
    @(negedge clk);
    cfg_we = 1'b0;
    exp_cur = 0;
  endtask

  task automatic do_req(input logic [31:0] va, input string req);
    bit f; logic [39:0] pa; int nf, n;
    model(va, f, pa, nf);
    @(negedge clk);
    fetch_cnt = 0; req_valid = 1'b1; req_va = va;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 300) begin @(negedge clk); n++; end
    if (!rsp_valid) begin
      check({req, " timeout"}, 64'h0, 64'h1);
    end else begin
      check({req, " fault"}, 64'(rsp_fault), 64'(f));
      check({req, " pa"}, 64'(rsp_pa), 64'(pa));
      check({req, " reads"}, 64'(fetch_cnt), 64'(nf));
      @(negedge clk);
      check("R11 pulse", 64'({rsp_valid, req_ready}), 64'b01);
    end
  endtask

  function automatic logic [31:0] va_of(input int w, input int idx, input int off);
    return {BASE_WIN + 12'(w), 8'(idx), 12'(off)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    check("R1 idle", 64'({req_ready, mem_req, rsp_valid}), 64'b100);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", 64'({req_ready, mem_req, rsp_valid}), 64'b100);
    configure();
    do_req(va_of(0, 5, 12'hABC), "R1 R2 first table");
    do_req(va_of(0, 255, 12'h001), "R10 same window");
    do_req(va_of(2, 37, 12'h010), "R3 R4 invalid entry up two");
    do_req(va_of(1, 200, 12'h000), "R3 R5 reserved bit set down one");
    do_req(va_of(1, 3, 12'hFFF), "R10 cached window");
    do_req(BASE_WIN * 32'h100000 - 32'h4, "R7 below base");
    do_req(va_of(7, 9, 12'h123), "R8 wrap to window 1");
    do_req(va_of(12, 9, 12'h123), "R8 beyond two laps");
    do_req(va_of(5, 40, 12'h777), "R4 walk up to last");
    do_req(va_of(4, 0, 12'h000), "R3 R5 invalid first slot");
    do_req(va_of(0, 1, 12'h000), "R5 walk down to first");
    bad_next = 3;
    do_req(va_of(5, 2, 12'h002), "R6 broken link");
    do_req(va_of(3, 2, 12'h002), "R6 cache kept at break");
    bad_next = -1;
    do_req(va_of(5, 11, 12'h0A0), "R4 past repaired link");
    configure();
    do_req(va_of(0, 77, 12'h5A5), "R9 cache back to first");
    for (int r = 0; r < 300; r++) begin
      int w;
      w = int'($urandom % 14);
      if ($urandom % 16 == 0) do_req(32'($urandom % (BASE_WIN * 32'h100000)), "R7 random below");
      else do_req(va_of(w, int'($urandom % 256), int'($urandom % 4096)), "R2 R8 random");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule